// File: doc/BRIEF.md
# PCI Interrupt Line Router with Group Enables

This block sits between the level-sensitive interrupt requests of a PCI bus and a system interrupt controller. It carries 32 request lines straight through to 32 outputs. Each output is allowed to follow its input only while the enable of its group is set. There are eight groups of four lines. Each group has one 32-bit mapping register. Bit 31 of that register is the group enable, and bits 30:0 hold a fixed identification pattern that software can read back but cannot change.

Software reaches the eight registers through a simple strobe-based read/write port, decoded by a 16-bit offset. A power-on reset puts every register into its initial state. A separate device-reset input clears all group enables and keeps everything else.

The block also contains a small combinational calculator. It turns a device/function number and an interrupt pin into a line index. It has one formula for devices on the primary bus and another for devices behind a secondary bridge.

Top module: `pci_irq_router`

## Requirements
- R1: After `rst_n` is released, mapping register i (i = 0..7) reads 0x000007C0 | (i << 2), with bit 31 (enable) clear, and every `irq_out` line is low.
- R2: A write to a valid register word changes only bit 31 (the enable). Bits 30:0 read back unchanged whatever data was written.
- R3: A valid register word lies at an offset in 0xC00–0xC3F with offset bit 2 set. Offset bits 5:3 select the register, so register i is at 0xC00 + 8·i + 4.
- R4: Inside the window, a word with offset bit 2 clear reads as zero and ignores writes. Any offset outside the window reads as zero and ignores writes.
- R5: `irq_out[n]` equals `irq_in[n]` AND the enable of register n/4. The gating is combinational, so a change of input or enable reaches the output without waiting for a clock.
- R6: `irq_in` lines numbered 32 and above have no effect on any output.
- R7: A cycle with `dev_rst` high clears every enable bit and leaves bits 30:0 of every register unchanged. It takes priority over a register write in the same cycle.
- R8: Read data appears on `reg_rdata` after the clock edge that samples `reg_rd`. It holds its value until the next read.
- R9: With `map_secondary` low, `map_line` = `map_pin` + 16 when `map_devfn` bit 0 is set, and `map_pin` otherwise.
- R10: With `map_secondary` high, `map_line` = `map_devfn[4:3]`·4 + `map_pin`.
- R11: A register write takes effect on the clock edge that samples `reg_wr`. An output whose enable is cleared is low right after that edge, even while its input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| dev_rst | input | 1 | Synchronous device reset: clears all group enables |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 32 | Write data (only bit 31 is used) |
| reg_rdata | output | 32 | Registered read data |
| irq_in | input | 40 | Level interrupt requests; lines 32..39 are ignored |
| irq_out | output | 32 | Gated interrupt requests toward the controller |
| map_devfn | input | 8 | Device/function number for the index calculator |
| map_pin | input | 2 | Interrupt pin index (0..3) |
| map_secondary | input | 1 | 1: secondary-bridge formula, 0: primary-bus formula |
| map_line | output | 5 | Computed line index |

## Verification
The gating is first tried with all inputs high while single groups are enabled one at a time. This shows whether each enable bit reaches exactly its own four lines and no others. Random input levels are then combined with random enable patterns, reached through valid words, even words and out-of-window offsets. This separates correct address decoding from writes that leak into the wrong register. Held-high inputs with an enable being cleared, and with a device reset colliding with a write, show that the output drops right after the edge and that reset wins. The index calculator is swept over device/function numbers and pins in both modes, which separates the bit-0 primary offset from the bits-4:3 secondary slot field.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

    parameter int DATA_W        = 32;
    parameter int ADDR_W        = 16;
    parameter int NUM_GRPS      = 8;
    parameter int LINES_PER_GRP = 4;
    parameter int NUM_LINES     = NUM_GRPS * LINES_PER_GRP;
    parameter int SEL_W         = $clog2(NUM_GRPS);
    parameter int ENABLE_BIT    = DATA_W - 1;
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0C00;
    parameter logic [10:0] ID_FIELD = 11'h7C0;

    typedef struct packed {
        logic             in_window;
        logic             word_ok;
        logic [SEL_W-1:0] sel;
    } reg_access_t;

    function automatic logic [ENABLE_BIT-1:0] low_bits_init(logic [SEL_W-1:0] idx);
        return ENABLE_BIT'(ID_FIELD) | (ENABLE_BIT'(idx) << 2);
    endfunction

endpackage

// File: rtl/pci_irq_regs.sv
module pci_irq_regs
    import pci_irq_pkg::*;
#(
    parameter int GRPS = NUM_GRPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [GRPS-1:0]   grp_en
);
    localparam int LO = SEL_W + 3;

    typedef struct packed {
        logic [GRPS-1:0]   en;
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

    regs_state_t state_d, state_q;
    reg_access_t acc;

    always_comb begin
        acc.in_window = (reg_addr[ADDR_W-1:LO] == WIN_BASE[ADDR_W-1:LO]);
        acc.word_ok   = reg_addr[2];
        acc.sel       = reg_addr[LO-1:3];

        state_d = state_q;
        if (reg_wr && acc.in_window && acc.word_ok) begin
            state_d.en[acc.sel] = reg_wdata[ENABLE_BIT];
        end
        if (dev_rst) begin
            state_d.en = '0;
        end
        if (reg_rd) begin
            if (acc.in_window && acc.word_ok) begin
                state_d.rdata = {state_q.en[acc.sel], low_bits_init(acc.sel)};
            end else begin
                state_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.rdata;
    assign grp_en    = state_q.en;

    logic unused_regs;
    assign unused_regs = ^{reg_addr[1:0], reg_wdata[ENABLE_BIT-1:0]};

endmodule

// File: rtl/pci_irq_gate.sv
module pci_irq_gate
    import pci_irq_pkg::*;
#(
    parameter int GRPS = NUM_GRPS,
    parameter int LPG  = LINES_PER_GRP
) (
    input  logic [GRPS*LPG-1:0] lines_in,
    input  logic [GRPS-1:0]     grp_en,
    output logic [GRPS*LPG-1:0] lines_out
);
    for (genvar n = 0; n < GRPS * LPG; n++) begin : g_line
        assign lines_out[n] = lines_in[n] & grp_en[n / LPG];
    end
endmodule

// File: rtl/pci_irq_line_map.sv
module pci_irq_line_map
    import pci_irq_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int PIN_W  = 2,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic [7:0]        devfn,
    input  logic [PIN_W-1:0]  pin,
    input  logic              secondary,
    output logic [LINE_W-1:0] line
);
    localparam int HALF = LINES / 2;

    logic [LINE_W-1:0] prim_line, sec_line;

    always_comb begin
        prim_line = LINE_W'(pin) + (devfn[0] ? LINE_W'(HALF) : '0);
        sec_line  = (LINE_W'(devfn[4:3]) << PIN_W) + LINE_W'(pin);
        line      = secondary ? sec_line : prim_line;
    end

    logic unused_map;
    assign unused_map = ^{devfn[7:5], devfn[2:1]};
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_pkg::*;
#(
    parameter int IN_LINES = 40,
    parameter int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dev_rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [IN_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic [7:0]          map_devfn,
    input  logic [1:0]          map_pin,
    input  logic                map_secondary,
    output logic [LINE_W-1:0]   map_line
);
    logic [NUM_GRPS-1:0] grp_en;

    pci_irq_regs #(.GRPS(NUM_GRPS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_rst   (dev_rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .grp_en    (grp_en)
    );

    pci_irq_gate #(.GRPS(NUM_GRPS), .LPG(LINES_PER_GRP)) u_gate (
        .lines_in  (irq_in[NUM_LINES-1:0]),
        .grp_en    (grp_en),
        .lines_out (irq_out)
    );

    pci_irq_line_map #(.LINES(NUM_LINES), .PIN_W(2), .LINE_W(LINE_W)) u_map (
        .devfn     (map_devfn),
        .pin       (map_pin),
        .secondary (map_secondary),
        .line      (map_line)
    );

    logic unused_hi;
    assign unused_hi = ^irq_in[IN_LINES-1:NUM_LINES];
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk
    import pci_irq_pkg::*;
#(
    parameter int IN_LINES = 40,
    parameter int LINE_W   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dev_rst,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [IN_LINES-1:0]  irq_in,
    input logic [NUM_LINES-1:0] irq_out,
    input logic                 map_secondary,
    input logic [LINE_W-1:0]    map_line
);
    localparam int LO = SEL_W + 3;

    logic valid_word;
    assign valid_word = (reg_addr[ADDR_W-1:LO] == WIN_BASE[ADDR_W-1:LO]) && reg_addr[2];

    // R5
    out_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~irq_in[NUM_LINES-1:0]) == '0);

    // R7
    devrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> irq_out == '0);

    // R11
    disable_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && valid_word && !reg_wdata[ENABLE_BIT] && !dev_rst) |=>
        ((irq_out >> {$past(reg_addr[LO-1:3]), 2'b00}) & NUM_LINES'(4'hF)) == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R4
    even_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_addr[2]) |=> reg_rdata == '0);

    // R10
    sec_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_secondary |-> !map_line[LINE_W-1]);

    // R9
    prim_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_secondary |-> map_line[3:2] == 2'b00);
endmodule

bind pci_irq_router pci_irq_router_chk #(.IN_LINES(IN_LINES), .LINE_W(LINE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_rst       (dev_rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_in        (irq_in),
    .irq_out       (irq_out),
    .map_secondary (map_secondary),
    .map_line      (map_line)
);

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        dev_rst = 0;
    logic        reg_wr = 0;
    logic        reg_rd = 0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [39:0] irq_in = '0;
    logic [31:0] irq_out;
    logic [7:0]  map_devfn = '0;
    logic [1:0]  map_pin = '0;
    logic        map_secondary = 0;
    logic [4:0]  map_line;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] exp_en = '0;

    always #4 clk = ~clk;

    pci_irq_router u0 (.*);

    function automatic logic [31:0] exp_reg(int i);
        return {exp_en[i], 31'h7C0 | 31'(i << 2)};
    endfunction

    function automatic bit is_valid(logic [15:0] a);
        return (a[15:6] == 10'h030) && a[2];
    endfunction

    function automatic logic [31:0] exp_out(logic [39:0] inp);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) r[n] = inp[n] & exp_en[n / 4];
        return r;
    endfunction

    function automatic logic [4:0] exp_line(logic [7:0] d, logic [1:0] p, bit sec);
        if (sec) return 5'(({3'b0, d[4:3]} << 2) + p);
        return 5'((d[0] ? 16 : 0) + p);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (is_valid(a)) exp_en[a[5:3]] = d[31];
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic check_all_regs(string req);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(16'hC04 + 16'(i * 8), v);
            chk(req, v, exp_reg(i));
        end
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        irq_in = '1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out low", irq_out, 32'h0);
        check_all_regs("R1 init value");

        // R3 / R5: each group alone
        for (int i = 0; i < 8; i++) begin
            wr(16'hC04 + 16'(i * 8), 32'h8000_0000);
            #1 chk("R3 R5 single group", irq_out, exp_out(irq_in));
            wr(16'hC04 + 16'(i * 8), 32'h0);
        end

        // R2: junk low bits ignored
        wr(16'hC1C, 32'hFFFF_FFFF);
        wr(16'hC2C, 32'h7FFF_FFFF);
        check_all_regs("R2 only bit31");

        // R4: even word and out of window
        wr(16'hC00, 32'h8000_0000);
        wr(16'hC40 + 16'h4, 32'h8000_0000);
        wr(16'h1C04, 32'h8000_0000);
        wr(16'h0C3C - 16'h4, 32'hFFFF_FFFF);
        check_all_regs("R4 ignored writes");
        #1 chk("R4 outputs unchanged", irq_out, exp_out(irq_in));
        rd(16'hC18, v); chk("R4 even word reads 0", v, 32'h0);
        rd(16'hC44, v); chk("R4 outside reads 0", v, 32'h0);

        // R11: clear enable with inputs held high
        wr(16'hC0C, 32'h8000_0000);
        chk("R11 enabled", irq_out, exp_out(irq_in));
        @(negedge clk); reg_wr = 1; reg_addr = 16'hC0C; reg_wdata = 32'h0;
        @(posedge clk); #1;
        chk("R11 drop after edge", irq_out & 32'h0000_00F0, 32'h0);
        @(negedge clk); reg_wr = 0; exp_en[1] = 0;

        // R6: upper inputs ignored
        exp_en = '0;
        for (int i = 0; i < 8; i++) wr(16'hC04 + 16'(i * 8), 32'h8000_0000);
        irq_in = 40'hFF_0000_0000; #1;
        chk("R6 upper ignored", irq_out, 32'h0);
        irq_in = 40'h00_A5A5_5A5A; #1;
        chk("R6 lower pass", irq_out, 32'hA5A5_5A5A);

        // R7: device reset colliding with write
        @(negedge clk);
        dev_rst = 1; reg_wr = 1; reg_addr = 16'hC14; reg_wdata = 32'h8000_0000;
        @(negedge clk);
        dev_rst = 0; reg_wr = 0; exp_en = '0;
        chk("R7 outputs cleared", irq_out, 32'h0);
        check_all_regs("R7 low bits kept");

        // R8: hold without read
        rd(16'hC24, v);
        @(negedge clk); reg_addr = 16'hC00;
        @(negedge clk);
        chk("R8 held", reg_rdata, exp_reg(4));

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            int kind = int'($urandom_range(0, 3));
            a = 16'hC00 + 16'($urandom_range(0, 7) * 8);
            if (kind != 3) a = a + 16'h4;
            if (kind == 2 && $urandom_range(0, 1) == 1) a = a ^ 16'h2000;
            wr(a, $urandom());
            irq_in = {$urandom(), $urandom()};
            #1 chk("R5 random gating", irq_out, exp_out(irq_in));
        end
        check_all_regs("R2 R3 random readback");

        // R9 / R10: line index
        for (int d = 0; d < 256; d += 5) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 2; s++) begin
                    map_devfn = 8'(d); map_pin = 2'(p); map_secondary = s[0];
                    #1;
                    chk(s ? "R10 secondary index" : "R9 primary index",
                        {27'b0, map_line}, {27'b0, exp_line(8'(d), 2'(p), s[0])});
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule